// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds a parameterised number of interval timers (two by default), each reached through its own window of word registers on a single 32-bit read/write port. Every timer counts down from a programmed start value toward zero. A control byte sets how it runs. It can wrap to all ones and keep going, reload itself and repeat, or halt at zero until software loads it again. The decrement can be slowed by 16 or 256 with a small prescaler that gates the count enable. The clock is never divided.

Reaching zero is the only event a timer can signal. It latches a raw status flag. That flag, gated by a per-timer interrupt enable, drives one interrupt line per timer. A write of any value to the clear register drops the flag. Each timer has two ways to set its start value. An immediate load replaces the running count at once. A background load changes only the value taken at the next reload. A counter can also run 16 bits wide, using only the low half of its start value.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, each timer reads load 0, background load 0, control 0, raw status 0 and current value 0xFFFFFFFF, and every irq bit is low.
- R2: bus_word_addr holds {timer index, word index}, so timer k starts at word 8k (byte 0x20·k). The word indices are 0 load, 1 current value (read-only, writes ignored), 2 control (bits [7:0]), 3 clear (write-only, reads 0), 4 raw status (bit 0), 5 masked status (bit 0), 6 background load, and 7 unused (reads 0). Read data appears on bus_rdata one cycle after the address is presented.
- R3: A write to word 0 sets both the current count and the stored reload value. A write to word 6 sets only the stored reload value. Words 0 and 6 both read back the stored reload value.
- R4: While control bit 7 is 0, the count and the prescaler hold, except when a load write is made.
- R5: Control bits [3:2] set the ticks per decrement: 00 gives 1, 01 gives 16, and 10 or 11 give 256. A load write restarts the prescaler. A timer loaded with L while stopped and then enabled sets its raw status on the (L·div)-th clock edge after the enabling write.
- R6: Raw status is set on the tick that moves the count from 1 to 0.
- R7: In periodic mode (bit 6 = 1, bit 0 = 0), a tick at zero reloads the count from the stored reload value, so interrupts repeat every (L+1)·div cycles.
- R8: In one-shot mode (bit 0 = 1, which wins over bit 6), the count stays at zero after reaching it and raises no further interrupt.
- R9: In free-running mode (bits 6 and 0 both 0), a tick at zero wraps the count to all ones of the active width.
- R10: With bit 1 = 0, the counter is 16 bits wide. Load writes keep only bits [15:0] of the count, and the count wraps to 0x0000FFFF.
- R11: Masked status equals raw status AND control bit 5, and irq[k] equals timer k's masked status.
- R12: A write of any value to word 3 clears raw status. A zero reached on the same edge takes precedence and leaves the flag set.
- R13: Writes to one timer's window leave every other timer's registers, count and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word_addr | input | ADDR_W (4) | Word address: timer index above a 3-bit register index |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| irq | output | NUM_TIMERS (2) | Per-timer interrupt, equal to the masked status |

## Verification
The assertions assume that the bus changes only at clock edges and that any write lands on exactly one word, and they check each property only when no load write is hitting the same timer. The bench drives every bus access half a cycle away from the sampling edge. It changes control only while a timer is stopped or between measurements. Each cycle count it checks is measured from a known edge: the enabling write, or an interrupt-clear write issued the cycle after the previous interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int WORD_IDX_W = 3;
  localparam int CTRL_W     = 8;

  typedef enum logic [WORD_IDX_W-1:0] {
    REG_LOAD   = 3'd0,
    REG_VALUE  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_CLR    = 3'd3,
    REG_RAW    = 3'd4,
    REG_MSK    = 3'd5,
    REG_BGLOAD = 3'd6,
    REG_NONE   = 3'd7
  } reg_idx_e;

  // control byte bit positions
  localparam int CB_RUN      = 7;
  localparam int CB_PERIODIC = 6;
  localparam int CB_IE       = 5;
  localparam int CB_PRE_HI   = 3;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_WIDE     = 1;
  localparam int CB_ONESHOT  = 0;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_ALT256 = 2'b11
  } pre_sel_e;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } mode_e;

  // one-shot takes precedence over periodic
  function automatic mode_e decode_mode(input logic [CTRL_W-1:0] c);
    if (c[CB_ONESHOT])       return MODE_ONESHOT;
    else if (c[CB_PERIODIC]) return MODE_PERIODIC;
    else                     return MODE_FREE;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [HI_LOG-1:0] pre_q;
  pre_sel_e          sel_e;

  assign sel_e = pre_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      PRE_DIV1:  tick = run;
      PRE_DIV16: tick = run && (&pre_q[MID_LOG-1:0]);
      default:   tick = run && (&pre_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (run)       pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DATA_W  = 32,
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                sel_hit,
  input  logic                                bus_wr,
  input  logic [tmr_pkg::WORD_IDX_W-1:0]      reg_idx,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [DATA_W-1:0]                   rd_word,
  output logic                                irq,
  output logic [DATA_W-1:0]                   cnt_o,
  output logic [DATA_W-1:0]                   cnt_eff_o,
  output logic                                raw_o,
  output logic [tmr_pkg::CTRL_W-1:0]          ctrl_o,
  output logic                                tick_o
);
  import tmr_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ALL1  = '1;
  localparam logic [DATA_W-1:0] HALF1 = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE   = {{(DATA_W-1){1'b0}}, 1'b1};

  reg_idx_e            idx_e;
  logic                ld_wr, bg_wr, ctrl_wr, clr_wr;
  logic [DATA_W-1:0]   cnt_q, cnt_d, reload_q, mask, cnt_eff, rel_eff;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                raw_q, tick, zero_hit;
  mode_e               mode;

  assign idx_e   = reg_idx_e'(reg_idx);
  assign ld_wr   = bus_wr && sel_hit && (idx_e == REG_LOAD);
  assign bg_wr   = bus_wr && sel_hit && (idx_e == REG_BGLOAD);
  assign ctrl_wr = bus_wr && sel_hit && (idx_e == REG_CTRL);
  assign clr_wr  = bus_wr && sel_hit && (idx_e == REG_CLR);

  assign mask    = ctrl_q[CB_WIDE] ? ALL1 : HALF1;
  assign cnt_eff = cnt_q & mask;
  assign rel_eff = reload_q & mask;
  assign mode    = decode_mode(ctrl_q);

  tmr_prescale #(
    .MID_LOG (MID_LOG),
    .HI_LOG  (HI_LOG)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[CB_RUN]),
    .restart (ld_wr),
    .sel     (ctrl_q[CB_PRE_HI:CB_PRE_LO]),
    .tick    (tick)
  );

  // next count and zero event
  always_comb begin
    cnt_d    = cnt_q;
    zero_hit = 1'b0;
    if (ld_wr) begin
      cnt_d = wdata & mask;
    end else if (tick) begin
      if (cnt_eff == '0) begin
        unique case (mode)
          MODE_PERIODIC: cnt_d = rel_eff;
          MODE_FREE:     cnt_d = mask;
          default:       cnt_d = cnt_q;
        endcase
      end else begin
        cnt_d    = cnt_eff - ONE;
        zero_hit = (cnt_eff == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= ALL1;
      reload_q <= '0;
      ctrl_q   <= '0;
      raw_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld_wr || bg_wr) reload_q <= wdata;
      if (ctrl_wr)        ctrl_q   <= wdata[CTRL_W-1:0];
      if (zero_hit)       raw_q    <= 1'b1;
      else if (clr_wr)    raw_q    <= 1'b0;
    end
  end

  always_comb begin
    unique case (idx_e)
      REG_LOAD, REG_BGLOAD: rd_word = reload_q;
      REG_VALUE:            rd_word = cnt_q;
      REG_CTRL:             rd_word = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      REG_RAW:              rd_word = {{(DATA_W-1){1'b0}}, raw_q};
      REG_MSK:              rd_word = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q[CB_IE]};
      default:              rd_word = '0;
    endcase
  end

  assign irq       = raw_q & ctrl_q[CB_IE];
  assign cnt_o     = cnt_q;
  assign cnt_eff_o = cnt_eff;
  assign raw_o     = raw_q;
  assign ctrl_o    = ctrl_q;
  assign tick_o    = tick;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter  int NUM_TIMERS = 2,
  parameter  int DATA_W     = 32,
  parameter  int MID_LOG    = 4,
  parameter  int HI_LOG     = 8,
  localparam int SEL_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W     = SEL_W + tmr_pkg::WORD_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_word_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  import tmr_pkg::*;

  logic [SEL_W-1:0]                        tsel;
  logic [WORD_IDX_W-1:0]                   widx;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]       word_all;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]       cnt_all;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]       eff_all;
  logic [NUM_TIMERS-1:0][CTRL_W-1:0]       ctrl_all;
  logic [NUM_TIMERS-1:0]                   raw_all;
  logic [NUM_TIMERS-1:0]                   tick_all;
  logic [DATA_W-1:0]                       rd_next;

  assign tsel = bus_word_addr[ADDR_W-1:WORD_IDX_W];
  assign widx = bus_word_addr[WORD_IDX_W-1:0];

  for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_tmr
    tmr_core #(
      .DATA_W  (DATA_W),
      .MID_LOG (MID_LOG),
      .HI_LOG  (HI_LOG)
    ) u_core (
      .clk       (clk),
      .rst       (rst),
      .sel_hit   (tsel == SEL_W'(k)),
      .bus_wr    (bus_wr),
      .reg_idx   (widx),
      .wdata     (bus_wdata),
      .rd_word   (word_all[k]),
      .irq       (irq[k]),
      .cnt_o     (cnt_all[k]),
      .cnt_eff_o (eff_all[k]),
      .raw_o     (raw_all[k]),
      .ctrl_o    (ctrl_all[k]),
      .tick_o    (tick_all[k])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_TIMERS; k++) begin
      if (tsel == SEL_W'(k)) rd_next = word_all[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 1,
  parameter int ADDR_W     = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              bus_wr,
  input logic [ADDR_W-1:0]                 bus_word_addr,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_eff,
  input logic [NUM_TIMERS-1:0][7:0]        ctrl,
  input logic [NUM_TIMERS-1:0]             raw,
  input logic [NUM_TIMERS-1:0]             tick
);
  localparam logic [DATA_W-1:0] ALL1  = '1;
  localparam logic [DATA_W-1:0] HALF1 = {{(DATA_W-DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

  for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_chk
    logic hit, ld, clr;
    assign hit = bus_wr && (bus_word_addr[ADDR_W-1:ADDR_W-SEL_W] == SEL_W'(k));
    assign ld  = hit && (bus_word_addr[ADDR_W-SEL_W-1:0] == '0);
    assign clr = hit && (bus_word_addr[ADDR_W-SEL_W-1:0] == 3'd3);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cnt[k] == ALL1 && !raw[k]));

    assert_frozen_when_off_R4: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[k][7] && !ld) |=> $stable(cnt[k]));

    assert_raw_only_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(raw[k]) |-> (cnt_eff[k] == '0));

    assert_oneshot_holds_R8: assert property (@(posedge clk) disable iff (rst)
      (ctrl[k][7] && ctrl[k][0] && cnt_eff[k] == '0 && !ld) |=> $stable(cnt[k]));

    assert_free_wrap_R9: assert property (@(posedge clk) disable iff (rst)
      (tick[k] && !ctrl[k][0] && !ctrl[k][6] && cnt_eff[k] == '0 && !ld)
      |=> (cnt[k] == ($past(ctrl[k][1]) ? ALL1 : HALF1)));

    assert_clear_drops_raw_R12: assert property (@(posedge clk) disable iff (rst)
      clr |=> (!raw[k] || cnt_eff[k] == '0));
  end

endmodule

bind dual_interval_timer timer_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .DATA_W     (DATA_W),
  .SEL_W      (SEL_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_wr        (bus_wr),
  .bus_word_addr (bus_word_addr),
  .cnt           (cnt_all),
  .cnt_eff       (eff_all),
  .ctrl          (ctrl_all),
  .raw           (raw_all),
  .tick          (tick_all)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_word_addr = '0;
  logic [31:0]   bus_wdata = '0;
  wire  [31:0]   bus_rdata;
  wire  [NT-1:0] irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer u_dut (
    .clk           (clk),
    .rst           (rst),
    .bus_word_addr (bus_word_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq           (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int t, input int idx, input logic [31:0] d);
    bus_word_addr = AW'(t * 8 + idx);
    bus_wdata     = d;
    bus_wr        = 1'b1;
    @(posedge clk); #1;
    bus_wr        = 1'b0;
  endtask

  task automatic rd(input int t, input int idx, output logic [31:0] d);
    bus_word_addr = AW'(t * 8 + idx);
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int t, input int lim, output int n);
    n = 0;
    while (!irq[t] && n < lim) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic idle(input int c);
    repeat (c) begin @(posedge clk); #1; end
  endtask

  function automatic int div_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 16;
    return 256;
  endfunction

  initial begin : main
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int t = 0; t < NT; t++) begin
      rd(t, 0, v); check("R1 load", v, 32'h0);
      rd(t, 6, v); check("R1 bgload", v, 32'h0);
      rd(t, 1, v); check("R1 value", v, 32'hFFFF_FFFF);
      rd(t, 2, v); check("R1 ctrl", v, 32'h0);
      rd(t, 4, v); check("R1 raw", v, 32'h0);
    end
    check("R1 irq", {30'h0, irq}, 32'h0);

    // R2 map, read-only value, unmapped word, window separation; R4 freeze
    for (int t = 0; t < NT; t++) begin
      wr(t, 2, 32'h02);
      wr(t, 0, 32'd7);
      wr(t, 1, 32'h1234);
      idle(20);
      rd(t, 1, v); check("R2/R4 value kept", v, 32'd7);
      rd(t, 7, v); check("R2 unused word", v, 32'h0);
      rd(t, 3, v); check("R2 clear reads 0", v, 32'h0);
      rd(t, 2, v); check("R2 ctrl readback", v, 32'h02);
      rd(1 - t, 0, v); check("R13 other window", v, (t == 1) ? 32'd7 : 32'd0);
    end

    // R3 immediate vs background load
    for (int t = 0; t < NT; t++) begin
      wr(t, 2, 32'h02);
      wr(t, 3, 32'h0);
      wr(t, 0, 32'd9);
      wr(t, 6, 32'd4);
      rd(t, 1, v); check("R3 count untouched by bg", v, 32'd9);
      rd(t, 0, v); check("R3 load reads reload", v, 32'd4);
      rd(t, 6, v); check("R3 bg reads reload", v, 32'd4);
      wr(t, 2, 32'hE2);
      wait_irq(t, 100, n); check("R3 first period", n, 32'd9);
      wr(t, 3, 32'h0);
      wait_irq(t, 100, n); check("R3 bg reload period", n, 32'd4);
      wr(t, 2, 32'h02);
      wr(t, 3, 32'h0);
    end

    // R5 prescale, R7 periodic, R13 independence
    for (int t = 0; t < NT; t++) begin
      for (int code = 0; code < 4; code++) begin
        for (int li = 0; li < 3; li++) begin
          int L, dv, base;
          L    = (li == 0) ? 1 : (li == 1) ? 3 : 6;
          dv   = div_of(code);
          base = 32'h02 | (code << 2);
          wr(t, 2, base);
          wr(t, 3, 32'h0);
          wr(t, 0, L);
          wr(t, 2, 32'hE0 | base);
          wait_irq(t, L * dv + 50, n);
          check($sformatf("R5 t%0d code%0d L%0d", t, code, L), n, L * dv);
          check("R13 other irq quiet", {31'h0, irq[1 - t]}, 32'h0);
          wr(t, 3, 32'h0);
          wait_irq(t, (L + 1) * dv + 50, n);
          check($sformatf("R7 t%0d code%0d L%0d", t, code, L), n, (L + 1) * dv - 1);
          wr(t, 2, base);
          wr(t, 3, 32'h0);
        end
      end
    end

    // R7 reload value observed; R6 count at zero when flag sets
    wr(0, 2, 32'h02);
    wr(0, 0, 32'd4);
    wr(0, 2, 32'hE2);
    wait_irq(0, 50, n);
    rd(0, 1, v); check("R6 count zero at flag", v, 32'h0);
    rd(0, 1, v); check("R7 reloaded", v, 32'd4);
    wr(0, 2, 32'h02);
    wr(0, 3, 32'h0);

    // R8 one-shot
    for (int t = 0; t < NT; t++) begin
      for (int code = 0; code < 2; code++) begin
        for (int li = 0; li < 2; li++) begin
          int L, dv, base;
          L    = (li == 0) ? 2 : 5;
          dv   = div_of(code);
          base = 32'h03 | (code << 2);
          wr(t, 2, base);
          wr(t, 3, 32'h0);
          wr(t, 0, L);
          wr(t, 2, 32'hA0 | base);
          wait_irq(t, L * dv + 50, n);
          check("R8 one-shot delay", n, L * dv);
          wr(t, 3, 32'h0);
          idle(4 * (L + 1) * dv);
          check("R8 no second irq", {31'h0, irq[t]}, 32'h0);
          rd(t, 1, v); check("R8 halted at zero", v, 32'h0);
          wr(t, 2, base);
        end
      end
    end
    // R8 one-shot bit wins over periodic bit
    wr(1, 2, 32'h03);
    wr(1, 0, 32'd3);
    wr(1, 2, 32'hE3);
    wait_irq(1, 50, n); check("R8 priority delay", n, 32'd3);
    wr(1, 3, 32'h0);
    idle(20);
    check("R8 priority no repeat", {31'h0, irq[1]}, 32'h0);
    wr(1, 2, 32'h03);

    // R9 free-running wrap
    for (int t = 0; t < NT; t++) begin
      wr(t, 2, 32'h02);
      wr(t, 0, 32'd3);
      wr(t, 2, 32'hA2);
      wait_irq(t, 50, n); check("R9 delay", n, 32'd3);
      rd(t, 1, v); check("R9 at zero", v, 32'h0);
      rd(t, 1, v); check("R9 wrapped", v, 32'hFFFF_FFFF);
      wr(t, 2, 32'h02);
      wr(t, 3, 32'h0);
    end

    // R10 16-bit counter
    for (int t = 0; t < NT; t++) begin
      wr(t, 2, 32'h00);
      wr(t, 0, 32'h0001_0004);
      rd(t, 0, v); check("R10 reload keeps full word", v, 32'h0001_0004);
      rd(t, 1, v); check("R10 count low half", v, 32'h0000_0004);
      wr(t, 2, 32'hA0);
      wait_irq(t, 50, n); check("R10 delay", n, 32'd4);
      rd(t, 1, v); check("R10 at zero", v, 32'h0);
      rd(t, 1, v); check("R10 wrap 16", v, 32'h0000_FFFF);
      wr(t, 2, 32'h00);
      wr(t, 3, 32'h0);
    end

    // R11 masking, R12 clear
    for (int t = 0; t < NT; t++) begin
      wr(t, 2, 32'h03);
      wr(t, 0, 32'd2);
      wr(t, 2, 32'h83);
      idle(6);
      check("R11 masked irq low", {31'h0, irq[t]}, 32'h0);
      rd(t, 4, v); check("R11 raw set", v, 32'h1);
      rd(t, 5, v); check("R11 masked clear", v, 32'h0);
      wr(t, 2, 32'hA3);
      check("R11 irq follows enable", {31'h0, irq[t]}, 32'h1);
      rd(t, 5, v); check("R11 masked set", v, 32'h1);
      wr(t, 3, 32'hDEAD_BEEF);
      check("R12 irq cleared", {31'h0, irq[t]}, 32'h0);
      rd(t, 4, v); check("R12 raw cleared", v, 32'h0);
      wr(t, 2, 32'h03);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule